// File: doc/BRIEF.md
# Tensor Copy Descriptor Legality Checker

This block screens the fields of a multidimensional tensor copy descriptor before the descriptor is written anywhere. A producer presents every field at once on a parallel input and raises a valid strobe for one cycle. The fields are the element type code, the rank, the low bits of the descriptor's storage address and of the tensor base address, the per-dimension sizes, byte strides, box sizes and element strides, and the interleave, swizzle and fill modes.

One cycle after the strobe, the block presents a registered verdict. The verdict is a mask with one bit per legality rule, plus an accept bit that is high only when no rule failed. Many rules depend on more than one field. Alignment needs change with the interleave mode and with the packed element types. The swizzle span limit is compared against the inner box length in bytes, which in turn depends on the element size.

The element size is expressed in half-byte units, indexed by type code:
- codes 0..12 give 2, 4, 8, 8, 16, 16, 4, 8, 16, 4, 8, 8, 8;
- code 13 is a 4-bit packed type, 8-byte aligned, and gives 1;
- codes 14 (4-bit packed) and 15 (6-bit packed) are 16-byte aligned and give 2.

Codes 6..12 are floating point. The inner box length is box[0] times these units. Interleave codes are 0 none, 1 16-byte, 2 32-byte and 3 reserved. Swizzle codes are 0 none, 1 32-byte span, 2 64-byte span, 3..6 128-byte span and 7 reserved. Dimension i is active when i < rank. Stride i is active when i < rank-1.

Top module: `tensor_desc_checker`

## Requirements
- R1: When `in_valid` is high at a clock edge, `res_valid` is high after that edge and `res_fail` carries the rule mask for those fields. `res_ok` is high exactly when that mask is zero. After an edge with `in_valid` low, all three result outputs are zero. Reset clears them too.
- R2: Bit 0 is set when the descriptor storage address is not a multiple of 64.
- R3: Bit 1 is set when the rank is 0 or above 5, or when the rank is below 3 with a non-zero interleave code.
- R4: Bit 2 is set when the base address is not a multiple of 16. It is also set when the base address is not a multiple of 32 under interleave code 2 or type codes 14 and 15.
- R5: Bit 3 is set when any active dimension size is 0 or exceeds 2^32. Inactive dimensions are ignored.
- R6: Bit 4 is set when dimension 0 is not a multiple of 128 for type codes 14 and 15, or is odd for type code 13.
- R7: Bit 5 is set when any active stride is not a multiple of 16 or is at least 2^40. It is also set when an active stride is not a multiple of 32 under the wide-alignment condition of R4.
- R8: Bit 6 is set when any active box size is 0 or above 256.
- R9: Bit 7 is set when the interleave code is 0 and the inner box length is not a multiple of 16 bytes.
- R10: Bit 8 is set when any active element stride is 0 or above 8.
- R11: Bit 9 is set when the interleave code is 0, the swizzle code is 1..6, and the inner box length exceeds that swizzle's span.
- R12: Bit 10 is set when the interleave code is 2 and the swizzle code is not 1.
- R13: Bit 11 is set when the NaN fill mode is requested with a type code outside 6..12.
- R14: Bit 12 is set when the interleave code is 3 or the swizzle code is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fields are valid this cycle |
| in_desc_lo | input | 6 | Low bits of the descriptor storage address |
| in_elem_type | input | 4 | Element type code |
| in_rank | input | RANK_W (3) | Number of dimensions |
| in_base_lo | input | 5 | Low bits of the tensor base address |
| in_dims | input | MAX_RANK*DIM_W | Dimension sizes; dimension i at bits [i*DIM_W +: DIM_W] |
| in_strides | input | (MAX_RANK-1)*STRIDE_W | Byte strides of dimensions 0..MAX_RANK-2 |
| in_boxes | input | MAX_RANK*BOX_W | Box sizes per dimension |
| in_estrides | input | MAX_RANK*ESTR_W | Element strides per dimension |
| in_interleave | input | 2 | Interleave code |
| in_swizzle | input | 3 | Swizzle code |
| in_nan_fill | input | 1 | Request NaN out-of-bound fill |
| res_valid | output | 1 | Verdict is present |
| res_ok | output | 1 | Descriptor accepted |
| res_fail | output | 13 | One bit per failed rule |

## Verification
A wrong rule term or a wrong size lookup inside the checker appears at the ports on the very next cycle. It shows as a mask bit that differs from what the rules predict for that field set, and usually as a flipped accept bit as well.

The hazard lies in the coupled rules, so the stimulus sits on the edges between them:
- rank-gated lanes that must be ignored;
- alignment that tightens under wide interleave or packed types;
- inner box lengths just at and just past a swizzle span.

A broken capture register shows up as a verdict a cycle late, or a verdict that lingers through idle cycles, and the scoreboard order catches that as a missing or surplus result.

// File: rtl/tdv_pkg.sv
`timescale 1ns/1ps
package tdv_pkg;
  localparam int NRULES = 13;

  localparam int RB_DESC    = 0;
  localparam int RB_RANK    = 1;
  localparam int RB_BASE    = 2;
  localparam int RB_DIM     = 3;
  localparam int RB_PACKDIM = 4;
  localparam int RB_STRIDE  = 5;
  localparam int RB_BOX     = 6;
  localparam int RB_INNER   = 7;
  localparam int RB_ESTR    = 8;
  localparam int RB_SPAN    = 9;
  localparam int RB_ILVSWZ  = 10;
  localparam int RB_FILL    = 11;
  localparam int RB_CODE    = 12;

  typedef enum logic [1:0] {
    ILV_NONE = 2'd0,
    ILV_16B  = 2'd1,
    ILV_32B  = 2'd2,
    ILV_RSVD = 2'd3
  } ilv_e;

  localparam logic [3:0] T_PK4_NARROW = 4'd13;
  localparam logic [3:0] T_PK4_WIDE   = 4'd14;
  localparam logic [3:0] T_PK6_WIDE   = 4'd15;

  // element footprint in half-byte units
  function automatic logic [4:0] half_units(input logic [3:0] t);
    case (t)
      4'd0:                                 return 5'd2;
      4'd1, 4'd6, 4'd9:                     return 5'd4;
      4'd2, 4'd3, 4'd7, 4'd10, 4'd11, 4'd12: return 5'd8;
      4'd4, 4'd5, 4'd8:                     return 5'd16;
      4'd13:                                return 5'd1;
      default:                              return 5'd2;
    endcase
  endfunction

  function automatic logic is_float(input logic [3:0] t);
    return (t >= 4'd6) && (t <= 4'd12);
  endfunction

  function automatic logic wide_packed(input logic [3:0] t);
    return (t == T_PK4_WIDE) || (t == T_PK6_WIDE);
  endfunction

  // swizzle span in half-byte units, 0 when no span applies
  function automatic logic [8:0] span_half(input logic [2:0] s);
    case (s)
      3'd1:                     return 9'd64;
      3'd2:                     return 9'd128;
      3'd3, 3'd4, 3'd5, 3'd6:   return 9'd256;
      default:                  return 9'd0;
    endcase
  endfunction
endpackage

// File: rtl/tdv_lane.sv
`timescale 1ns/1ps
module tdv_lane #(
  parameter int LANE            = 0,
  parameter int RANK_W          = 3,
  parameter int DIM_W           = 34,
  parameter int STRIDE_W        = 42,
  parameter int BOX_W           = 10,
  parameter int ESTR_W          = 4,
  parameter int DIM_LIM_LOG2    = 32,
  parameter int STRIDE_LIM_LOG2 = 40,
  parameter int BOX_MAX         = 256,
  parameter int ESTR_MAX        = 8
) (
  input  logic [RANK_W-1:0]   rank,
  input  logic                wide_align,
  input  logic [DIM_W-1:0]    dim,
  input  logic [STRIDE_W-1:0] stride,
  input  logic [BOX_W-1:0]    box,
  input  logic [ESTR_W-1:0]   estr,
  output logic                dim_bad,
  output logic                stride_bad,
  output logic                box_bad,
  output logic                estr_bad
);
  localparam logic [DIM_W-1:0]    DIM_ONE = 1;
  localparam logic [DIM_W-1:0]    DIM_CAP = DIM_ONE << DIM_LIM_LOG2;
  localparam logic [STRIDE_W-1:0] STR_ONE = 1;
  localparam logic [STRIDE_W-1:0] STR_CAP = STR_ONE << STRIDE_LIM_LOG2;
  localparam logic [BOX_W-1:0]    BOX_LIM = BOX_MAX[BOX_W-1:0];
  localparam logic [ESTR_W-1:0]   EST_LIM = ESTR_MAX[ESTR_W-1:0];

  logic dim_on, stride_on;
  assign dim_on    = int'(rank) > LANE;
  assign stride_on = int'(rank) > LANE + 1;

  assign dim_bad    = dim_on && ((dim == '0) || (dim > DIM_CAP));
  assign stride_bad = stride_on && ((stride[3:0] != 4'd0) ||
                                    (wide_align && stride[4]) ||
                                    (stride >= STR_CAP));
  assign box_bad    = dim_on && ((box == '0) || (box > BOX_LIM));
  assign estr_bad   = dim_on && ((estr == '0) || (estr > EST_LIM));
endmodule

// File: rtl/tdv_global.sv
`timescale 1ns/1ps
module tdv_global
  import tdv_pkg::*;
#(
  parameter int RANK_W   = 3,
  parameter int DIM_W    = 34,
  parameter int BOX_W    = 10,
  parameter int MAX_RANK = 5
) (
  input  logic [5:0]        desc_lo,
  input  logic [3:0]        etype,
  input  logic [RANK_W-1:0] rank,
  input  logic [4:0]        base_lo,
  input  logic [DIM_W-1:0]  dim0,
  input  logic [BOX_W-1:0]  box0,
  input  logic [1:0]        ilv,
  input  logic [2:0]        swz,
  input  logic              nan_fill,
  output logic              wide_align,
  output logic              desc_bad,
  output logic              rank_bad,
  output logic              base_bad,
  output logic              packdim_bad,
  output logic              inner_bad,
  output logic              span_bad,
  output logic              ilvswz_bad,
  output logic              fill_bad,
  output logic              code_bad
);
  localparam int IW = BOX_W + 5;

  logic [IW-1:0] inner_half;
  logic [8:0]    span;
  logic          ilv_none;

  assign ilv_none   = (ilv == ILV_NONE);
  assign wide_align = (ilv == ILV_32B) || wide_packed(etype);
  assign inner_half = {5'd0, box0} * {{BOX_W{1'b0}}, half_units(etype)};
  assign span       = span_half(swz);

  assign desc_bad    = (desc_lo != 6'd0);
  assign rank_bad    = (rank == '0) || (int'(rank) > MAX_RANK) ||
                       (!ilv_none && (int'(rank) < 3));
  assign base_bad    = wide_align ? (base_lo != 5'd0) : (base_lo[3:0] != 4'd0);
  assign packdim_bad = (wide_packed(etype) && (dim0[6:0] != 7'd0)) ||
                       ((etype == T_PK4_NARROW) && dim0[0]);
  assign inner_bad   = ilv_none && (inner_half[4:0] != 5'd0);
  assign span_bad    = ilv_none && (span != 9'd0) &&
                       (inner_half > {{(IW-9){1'b0}}, span});
  assign ilvswz_bad  = (ilv == ILV_32B) && (swz != 3'd1);
  assign fill_bad    = nan_fill && !is_float(etype);
  assign code_bad    = (ilv == ILV_RSVD) || (swz == 3'd7);
endmodule

// File: rtl/tensor_desc_checker.sv
`timescale 1ns/1ps
module tensor_desc_checker
  import tdv_pkg::*;
#(
  parameter int MAX_RANK        = 5,
  parameter int DIM_W           = 34,
  parameter int STRIDE_W        = 42,
  parameter int BOX_W           = 10,
  parameter int ESTR_W          = 4,
  parameter int DIM_LIM_LOG2    = 32,
  parameter int STRIDE_LIM_LOG2 = 40,
  parameter int BOX_MAX         = 256,
  parameter int ESTR_MAX        = 8,
  localparam int RANK_W         = $clog2(MAX_RANK + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [5:0]                       in_desc_lo,
  input  logic [3:0]                       in_elem_type,
  input  logic [RANK_W-1:0]                in_rank,
  input  logic [4:0]                       in_base_lo,
  input  logic [MAX_RANK*DIM_W-1:0]        in_dims,
  input  logic [(MAX_RANK-1)*STRIDE_W-1:0] in_strides,
  input  logic [MAX_RANK*BOX_W-1:0]        in_boxes,
  input  logic [MAX_RANK*ESTR_W-1:0]       in_estrides,
  input  logic [1:0]                       in_interleave,
  input  logic [2:0]                       in_swizzle,
  input  logic                             in_nan_fill,
  output logic                             res_valid,
  output logic                             res_ok,
  output logic [NRULES-1:0]                res_fail
);
  // rule events brought out for the checker
  logic [MAX_RANK-1:0] lane_dim_bad, lane_stride_bad, lane_box_bad, lane_estr_bad;
  logic wide_align;
  logic g_desc_bad, g_rank_bad, g_base_bad, g_packdim_bad, g_inner_bad;
  logic g_span_bad, g_ilvswz_bad, g_fill_bad, g_code_bad;
  logic [NRULES-1:0] fail_next;

  tdv_global #(
    .RANK_W(RANK_W), .DIM_W(DIM_W), .BOX_W(BOX_W), .MAX_RANK(MAX_RANK)
  ) u_global (
    .desc_lo    (in_desc_lo),
    .etype      (in_elem_type),
    .rank       (in_rank),
    .base_lo    (in_base_lo),
    .dim0       (in_dims[DIM_W-1:0]),
    .box0       (in_boxes[BOX_W-1:0]),
    .ilv        (in_interleave),
    .swz        (in_swizzle),
    .nan_fill   (in_nan_fill),
    .wide_align (wide_align),
    .desc_bad   (g_desc_bad),
    .rank_bad   (g_rank_bad),
    .base_bad   (g_base_bad),
    .packdim_bad(g_packdim_bad),
    .inner_bad  (g_inner_bad),
    .span_bad   (g_span_bad),
    .ilvswz_bad (g_ilvswz_bad),
    .fill_bad   (g_fill_bad),
    .code_bad   (g_code_bad)
  );

  for (genvar g = 0; g < MAX_RANK; g++) begin : g_lane
    logic [STRIDE_W-1:0] lane_stride;
    if (g < MAX_RANK - 1) begin : g_has_stride
      assign lane_stride = in_strides[g*STRIDE_W +: STRIDE_W];
    end else begin : g_no_stride
      assign lane_stride = '0;
    end

    tdv_lane #(
      .LANE(g), .RANK_W(RANK_W), .DIM_W(DIM_W), .STRIDE_W(STRIDE_W),
      .BOX_W(BOX_W), .ESTR_W(ESTR_W), .DIM_LIM_LOG2(DIM_LIM_LOG2),
      .STRIDE_LIM_LOG2(STRIDE_LIM_LOG2), .BOX_MAX(BOX_MAX), .ESTR_MAX(ESTR_MAX)
    ) u_lane (
      .rank      (in_rank),
      .wide_align(wide_align),
      .dim       (in_dims[g*DIM_W +: DIM_W]),
      .stride    (lane_stride),
      .box       (in_boxes[g*BOX_W +: BOX_W]),
      .estr      (in_estrides[g*ESTR_W +: ESTR_W]),
      .dim_bad   (lane_dim_bad[g]),
      .stride_bad(lane_stride_bad[g]),
      .box_bad   (lane_box_bad[g]),
      .estr_bad  (lane_estr_bad[g])
    );
  end

  always_comb begin
    fail_next             = '0;
    fail_next[RB_DESC]    = g_desc_bad;
    fail_next[RB_RANK]    = g_rank_bad;
    fail_next[RB_BASE]    = g_base_bad;
    fail_next[RB_DIM]     = |lane_dim_bad;
    fail_next[RB_PACKDIM] = g_packdim_bad;
    fail_next[RB_STRIDE]  = |lane_stride_bad;
    fail_next[RB_BOX]     = |lane_box_bad;
    fail_next[RB_INNER]   = g_inner_bad;
    fail_next[RB_ESTR]    = |lane_estr_bad;
    fail_next[RB_SPAN]    = g_span_bad;
    fail_next[RB_ILVSWZ]  = g_ilvswz_bad;
    fail_next[RB_FILL]    = g_fill_bad;
    fail_next[RB_CODE]    = g_code_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_fail  <= '0;
    end else begin
      res_valid <= in_valid;
      res_ok    <= in_valid && (fail_next == '0);
      res_fail  <= in_valid ? fail_next : '0;
    end
  end
endmodule

// File: rtl/tdv_chk.sv
`timescale 1ns/1ps
module tdv_chk
  import tdv_pkg::*;
#(
  parameter int RANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [5:0]        in_desc_lo,
  input logic [3:0]        in_elem_type,
  input logic [RANK_W-1:0] in_rank,
  input logic [1:0]        in_interleave,
  input logic [2:0]        in_swizzle,
  input logic              in_nan_fill,
  input logic              res_valid,
  input logic              res_ok,
  input logic [NRULES-1:0] res_fail,
  input logic [NRULES-1:0] fail_next
);
  // R1
  res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && !res_ok && (res_fail == '0)));
  // R1
  ok_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ok == (res_fail == '0)));
  // R1
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_fail == $past(fail_next)));
  // R2
  desc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_desc_lo != 6'd0)) |=> res_fail[RB_DESC]);
  // R3
  rank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_rank == '0)) |=> res_fail[RB_RANK]);
  // R12
  ilv_swz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_interleave == 2'd2) && (in_swizzle != 3'd1)) |=> res_fail[RB_ILVSWZ]);
  // R13
  fill_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_nan_fill && (in_elem_type < 4'd6)) |=> res_fail[RB_FILL]);
  // R14
  rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_interleave == 2'd3)) |=> res_fail[RB_CODE]);
endmodule

bind tensor_desc_checker tdv_chk #(.RANK_W(RANK_W)) u_tdv_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_desc_lo   (in_desc_lo),
  .in_elem_type (in_elem_type),
  .in_rank      (in_rank),
  .in_interleave(in_interleave),
  .in_swizzle   (in_swizzle),
  .in_nan_fill  (in_nan_fill),
  .res_valid    (res_valid),
  .res_ok       (res_ok),
  .res_fail     (res_fail),
  .fail_next    (fail_next)
);

// File: tb/test_tensor_desc_checker.sv
`timescale 1ns/1ps
module test_tensor_desc_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0;
  logic [5:0]    in_desc_lo = '0;
  logic [3:0]    in_elem_type = '0;
  logic [2:0]    in_rank = '0;
  logic [4:0]    in_base_lo = '0;
  logic [169:0]  in_dims = '0;
  logic [167:0]  in_strides = '0;
  logic [49:0]   in_boxes = '0;
  logic [19:0]   in_estrides = '0;
  logic [1:0]    in_interleave = '0;
  logic [2:0]    in_swizzle = '0;
  logic          in_nan_fill = 1'b0;
  logic          res_valid, res_ok;
  logic [12:0]   res_fail;

  tensor_desc_checker i_tensor_desc_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_desc_lo(in_desc_lo),
    .in_elem_type(in_elem_type), .in_rank(in_rank), .in_base_lo(in_base_lo),
    .in_dims(in_dims), .in_strides(in_strides), .in_boxes(in_boxes),
    .in_estrides(in_estrides), .in_interleave(in_interleave),
    .in_swizzle(in_swizzle), .in_nan_fill(in_nan_fill),
    .res_valid(res_valid), .res_ok(res_ok), .res_fail(res_fail)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // descriptor under construction
  int unsigned d_desc, d_base, d_type, d_rank, d_ilv, d_swz;
  bit          d_nan;
  logic [33:0] d_dim [5];
  logic [41:0] d_str [4];
  int unsigned d_box [5];
  int unsigned d_est [5];

  logic [12:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [13:0] got, logic [13:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int unsigned elem_bits(int unsigned t);
    case (t)
      0: return 8;
      1, 6, 9: return 16;
      4, 5, 8: return 64;
      13: return 4;
      14, 15: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic logic [12:0] model();
    logic [12:0] m = '0;
    bit wide = (d_ilv == 2) || (d_type == 14) || (d_type == 15);
    longint unsigned inner_bits = longint'(d_box[0]) * elem_bits(d_type);
    int unsigned span_bytes = (d_swz == 1) ? 32 : (d_swz == 2) ? 64 :
                              (d_swz >= 3 && d_swz <= 6) ? 128 : 0;
    if (d_desc % 64 != 0) m[0] = 1'b1;
    if (d_rank < 1 || d_rank > 5 || (d_ilv != 0 && d_rank < 3)) m[1] = 1'b1;
    if (d_base % (wide ? 32 : 16) != 0) m[2] = 1'b1;
    for (int i = 0; i < 5; i++)
      if (i < int'(d_rank)) begin
        if (d_dim[i] == 0 || d_dim[i] > 34'h1_0000_0000) m[3] = 1'b1;
        if (d_box[i] == 0 || d_box[i] > 256) m[6] = 1'b1;
        if (d_est[i] == 0 || d_est[i] > 8) m[8] = 1'b1;
      end
    if ((d_type == 14 || d_type == 15) && (d_dim[0] % 128 != 0)) m[4] = 1'b1;
    if (d_type == 13 && (d_dim[0] % 2 != 0)) m[4] = 1'b1;
    for (int i = 0; i < 4; i++)
      if (i + 1 < int'(d_rank))
        if (d_str[i] % 16 != 0 || d_str[i] >= 42'h100_0000_0000 ||
            (wide && d_str[i] % 32 != 0)) m[5] = 1'b1;
    if (d_ilv == 0 && inner_bits % 128 != 0) m[7] = 1'b1;
    if (d_ilv == 0 && span_bytes != 0 && inner_bits > span_bytes * 8) m[9] = 1'b1;
    if (d_ilv == 2 && d_swz != 1) m[10] = 1'b1;
    if (d_nan && !(d_type >= 6 && d_type <= 12)) m[11] = 1'b1;
    if (d_ilv == 3 || d_swz == 7) m[12] = 1'b1;
    return m;
  endfunction

  task automatic set_default();
    d_desc = 32'h1000; d_base = 32'h2000; d_type = 7; d_rank = 3;
    d_ilv = 0; d_swz = 3; d_nan = 1'b0;
    d_dim[0] = 64; d_dim[1] = 32; d_dim[2] = 8; d_dim[3] = 1; d_dim[4] = 1;
    d_str[0] = 256; d_str[1] = 8192; d_str[2] = 65536; d_str[3] = 65536;
    d_box[0] = 32; d_box[1] = 8; d_box[2] = 2; d_box[3] = 1; d_box[4] = 1;
    for (int i = 0; i < 5; i++) d_est[i] = 1;
  endtask

  // driver: applies the descriptor for one cycle and queues the expectation
  task automatic send(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    in_desc_lo    = d_desc[5:0];
    in_base_lo    = d_base[4:0];
    in_elem_type  = d_type[3:0];
    in_rank       = d_rank[2:0];
    in_interleave = d_ilv[1:0];
    in_swizzle    = d_swz[2:0];
    in_nan_fill   = d_nan;
    for (int i = 0; i < 5; i++) begin
      in_dims[i*34 +: 34]    = d_dim[i];
      in_boxes[i*10 +: 10]   = d_box[i][9:0];
      in_estrides[i*4 +: 4]  = d_est[i][3:0];
    end
    for (int i = 0; i < 4; i++) in_strides[i*42 +: 42] = d_str[i];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops one expectation per result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected result", {res_ok, res_fail}, 14'h0);
      end else begin
        logic [12:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {res_ok, res_fail}, {(e == 13'd0), e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {res_valid, res_ok, res_fail}, 15'h0 >> 1);
    rst_n = 1'b1;
    @(negedge clk);

    set_default(); send("R1 legal baseline");
    set_default(); d_desc = 32'h1020; send("R2 desc misaligned");
    set_default(); d_desc = 32'h1040; d_nan = 1'b1; d_type = 2; send("R2 R13 combined");
    set_default(); d_rank = 0; send("R3 rank zero");
    set_default(); d_rank = 6; send("R3 rank six");
    set_default(); d_rank = 2; d_ilv = 1; send("R3 low rank interleaved");
    set_default(); d_rank = 1; d_str[0] = 3; send("R3 R7 rank one legal, stride ignored");
    set_default(); d_base = 32'h2008; send("R4 base 8");
    set_default(); d_base = 32'h2010; d_ilv = 2; d_swz = 1; send("R4 wide base");
    set_default(); d_dim[2] = 0; send("R5 zero dim");
    set_default(); d_dim[0] = 34'h1_0000_0000; send("R5 dim at cap");
    set_default(); d_dim[0] = 34'h1_0000_0001; send("R5 dim over cap");
    set_default(); d_dim[3] = 0; d_box[4] = 0; d_est[3] = 0; send("R5 R8 R10 inactive lanes");
    set_default(); d_type = 14; d_dim[0] = 64; send("R6 wide packed dim0");
    set_default(); d_type = 15; d_dim[0] = 256; send("R6 wide packed legal");
    set_default(); d_type = 13; d_dim[0] = 63; send("R6 narrow packed odd");
    set_default(); d_str[0] = 264; send("R7 stride not 16");
    set_default(); d_str[1] = 42'h100_0000_0000; send("R7 stride at cap");
    set_default(); d_type = 15; d_dim[0] = 128; d_str[0] = 272; send("R7 packed stride 32");
    set_default(); d_box[1] = 0; send("R8 zero box");
    set_default(); d_box[2] = 300; send("R8 box over 256");
    set_default(); d_box[2] = 256; send("R8 box at 256");
    set_default(); d_box[0] = 2; send("R9 inner 8 bytes");
    set_default(); d_box[0] = 2; d_ilv = 1; send("R9 interleaved ignores inner");
    set_default(); d_est[1] = 9; send("R10 estride 9");
    set_default(); d_est[0] = 0; send("R10 estride 0");
    set_default(); d_est[2] = 8; send("R10 estride 8");
    set_default(); d_swz = 1; send("R11 span 32 exceeded");
    set_default(); d_swz = 2; d_box[0] = 16; send("R11 span 64 exact");
    set_default(); d_swz = 6; d_box[0] = 64; send("R11 span 128 exceeded");
    set_default(); d_swz = 0; d_box[0] = 64; send("R11 no swizzle no span");
    set_default(); d_ilv = 2; d_swz = 3; send("R12 32B interleave swizzle");
    set_default(); d_nan = 1'b1; d_type = 2; send("R13 nan on integer");
    set_default(); d_nan = 1'b1; d_type = 9; send("R13 nan on float");
    set_default(); d_nan = 1'b1; d_type = 15; d_dim[0] = 128; send("R13 nan on packed");
    set_default(); d_ilv = 3; send("R14 reserved interleave");
    set_default(); d_swz = 7; send("R14 reserved swizzle");

    repeat (2) @(negedge clk);
    check("R1 idle outputs", {res_valid, res_ok, res_fail}, 15'h0 >> 1);
    check("R1 all results seen", 14'(exp_q.size()), 14'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule